// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog peripheral on a simple synchronous word-access register bus. A 64-bit up-counter is built from two 32-bit halves. Each half has its own release bit, and the counter has a run bit. A 64-bit expiry threshold is held in two 32-bit period words. Software loads the threshold, releases both counter halves and selects watchdog mode. It then arms the watchdog by writing a two-step key sequence into the upper half of the watchdog control word.

Once armed, the watchdog expires when the counter equals the threshold. Software keeps it alive by repeating the same key sequence, which clears the counter. A key value that is not accepted ends the watchdog at once. On expiry the block raises a one-cycle reset request and a sticky timeout flag. After expiry the watchdog stays in its expired state until the next hardware reset.

Register offsets: ID 0x00, counter low 0x10, counter high 0x14, period low 0x18, period high 0x1C, run control 0x20, global control 0x24, watchdog control 0x28. Reads are combinational from `addr_i`. Writes take effect at the clock edge where `req_i` and `we_i` are both high.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the following hold: `rst_req_o` and `timeout_o` are low; the ID offset reads the `ID_VALUE` parameter; the counter, run control, global control and watchdog control words read 0.
- R2: Each counter half reads 0 while its release bit is 0 (global control bit 0 for the low half, bit 1 for the high half). The 64-bit counter advances by one per clock only while run control bit 7 and both release bits are 1. A carry out of the low half increments the high half.
- R3: A write to a counter half loads that half only while run control bit 7 is 0. While the bit is 1, the write is ignored and counting continues.
- R4: The period words read back as written and form the 64-bit threshold {high, low}. While the watchdog is armed, `rst_req_o` is high in the cycle after the one in which the counter equals the threshold.
- R5: Arming requires global control bit 3 (watchdog mode) to be 1. Software writes key 0xA5C6 and then key 0xDA7E in watchdog control bits 31:16, with bit 14 set in both writes. Watchdog control bit 14 then reads 1. Arming leaves the counter value unchanged.
- R6: While armed, a completed 0xA5C6 then 0xDA7E sequence clears the whole counter to 0 at the edge of the second write.
- R7: In watchdog mode, a watchdog control write forces a timeout in the cycle after the write in either of two cases: the key is nonzero and is neither valid key, or the key is 0xDA7E and does not follow an accepted 0xA5C6. A key field of 0 takes no part in the sequence.
- R8: While watchdog mode is 0, watchdog control writes do not arm the watchdog and do not cause a timeout.
- R9: Once armed, the watchdog stays armed. Writes cannot clear global control bit 3 or watchdog control bit 14; only a hardware reset can.
- R10: `rst_req_o` is high for exactly one cycle per timeout. After the first timeout, no further request occurs until a hardware reset.
- R11: A timeout sets `timeout_o`, which also reads as watchdog control bit 15. The flag clears only when software writes 1 to bit 15; writing 0 to bit 15 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| rst_req_o | output | 1 | One-cycle reset request on timeout |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The hardest case to reach from the ports is a threshold match that depends on the high counter half. Counting up from zero would take billions of cycles to get there. Arming does not clear the counter, so the bench loads both counter halves while the counter is stopped, arms the watchdog, and only then starts the counter a few counts below a threshold that has a nonzero high half. The carry from the low half into the high half is reached the same way, by preloading the low half two counts below its wrap point.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PER_LO = 8'h18;
  localparam logic [7:0] OFS_PER_HI = 8'h1C;
  localparam logic [7:0] OFS_RUN    = 8'h20;
  localparam logic [7:0] OFS_GLB    = 8'h24;
  localparam logic [7:0] OFS_WDC    = 8'h28;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_OPEN = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SEAL = 16'hDA7E;

  localparam int RUN_BIT    = 7;
  localparam int REL_LO_BIT = 0;
  localparam int REL_HI_BIT = 1;
  localparam int MODE_BIT   = 3;
  localparam int FLAG_BIT   = 15;
  localparam int EN_BIT     = 14;

  typedef enum logic [2:0] {
    S_IDLE, S_IDLE_K0, S_ACT, S_ACT_K0, S_EXP
  } wd_state_e;
endpackage

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rel_i,
  input  logic              count_en_i,
  input  logic              clr_i,
  input  logic [1:0]        ld_i,
  input  logic [HALF_W-1:0] ld_val_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [1:0][HALF_W-1:0] half_q;
  logic [2:0]             cy;

  assign cy[0] = count_en_i;

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign cy[g+1] = cy[g] & (&half_q[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           half_q[g] <= '0;
      else if (!rel_i[g])    half_q[g] <= '0;
      else if (clr_i)        half_q[g] <= '0;
      else if (ld_i[g])      half_q[g] <= ld_val_i;
      else if (cy[g])        half_q[g] <= half_q[g] + 1'b1;
    end
  end

  assign cnt_o = half_q;
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 'h5744_0001,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic [1:0]        rel_o,
  output logic              mode_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [1:0]        cnt_ld_o,
  output logic              wdc_wr_o
);
  logic                   run_q, mode_q;
  logic [1:0]             rel_q;
  logic [1:0][DATA_W-1:0] per_q;
  logic                   wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      rel_q  <= '0;
      per_q  <= '0;
    end else if (wr) begin
      case (addr_i)
        ADDR_W'(OFS_RUN):    run_q    <= wdata_i[RUN_BIT];
        ADDR_W'(OFS_GLB): begin
          rel_q  <= {wdata_i[REL_HI_BIT], wdata_i[REL_LO_BIT]};
          mode_q <= wdata_i[MODE_BIT] | lock_i;  // mode sticks once armed
        end
        ADDR_W'(OFS_PER_LO): per_q[0] <= wdata_i;
        ADDR_W'(OFS_PER_HI): per_q[1] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cnt_ld_o[0] = wr && !run_q && (addr_i == ADDR_W'(OFS_CNT_LO));
  assign cnt_ld_o[1] = wr && !run_q && (addr_i == ADDR_W'(OFS_CNT_HI));
  assign wdc_wr_o    = wr && (addr_i == ADDR_W'(OFS_WDC));

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_ID):     rdata_o = ID_VALUE;
      ADDR_W'(OFS_CNT_LO): rdata_o = cnt_i[DATA_W-1:0];
      ADDR_W'(OFS_CNT_HI): rdata_o = cnt_i[CNT_W-1:DATA_W];
      ADDR_W'(OFS_PER_LO): rdata_o = per_q[0];
      ADDR_W'(OFS_PER_HI): rdata_o = per_q[1];
      ADDR_W'(OFS_RUN):    rdata_o[RUN_BIT] = run_q;
      ADDR_W'(OFS_GLB): begin
        rdata_o[MODE_BIT]   = mode_q;
        rdata_o[REL_LO_BIT] = rel_q[0];
        rdata_o[REL_HI_BIT] = rel_q[1];
      end
      ADDR_W'(OFS_WDC): begin
        rdata_o[FLAG_BIT] = flag_i;
        rdata_o[EN_BIT]   = lock_i;
      end
      default: ;
    endcase
  end

  assign run_o    = run_q;
  assign rel_o    = rel_q;
  assign mode_o   = mode_q;
  assign period_o = per_q;
endmodule

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_i,
  input  logic             flag_clr_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             active_o,
  output logic             expired_o,
  output logic             svc_clr_o,
  output logic             rst_req_o,
  output logic             flag_o
);
  wd_state_e state_q, state_d;
  logic key_open, key_seal, key_bad, seq_go, in_k0, act;
  logic bad_ev, hit_ev, tmo;
  logic rst_req_q, flag_q;

  always_comb begin
    key_open = (key_i == KEY_OPEN);
    key_seal = (key_i == KEY_SEAL);
    key_bad  = !key_open && !key_seal && (key_i != '0);
    seq_go   = wr_i && mode_i && (state_q != S_EXP);
    in_k0    = (state_q == S_IDLE_K0) || (state_q == S_ACT_K0);
    act      = (state_q == S_ACT) || (state_q == S_ACT_K0);
    bad_ev   = seq_go && (key_bad || (key_seal && en_i && !in_k0));
    hit_ev   = act && (cnt_i == period_i);
    tmo      = bad_ev || hit_ev;
    state_d   = state_q;
    svc_clr_o = 1'b0;
    if (tmo) begin
      state_d = S_EXP;
    end else if (seq_go && en_i) begin
      if (key_open) begin
        state_d = act ? S_ACT_K0 : S_IDLE_K0;
      end else if (key_seal && in_k0) begin
        state_d   = S_ACT;
        svc_clr_o = (state_q == S_ACT_K0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      rst_req_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= tmo;
      if (tmo)                    flag_q <= 1'b1;
      else if (wr_i && flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign active_o  = (state_q == S_ACT) || (state_q == S_ACT_K0);
  assign expired_o = (state_q == S_EXP);
  assign rst_req_o = rst_req_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] ID_VALUE = 'h5744_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              timeout_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic             run, mode_q, wdc_wr, svc_clr, count_en;
  logic             wd_active, wd_expired, lock;
  logic [1:0]       rel, cnt_ld;
  logic [CNT_W-1:0] cnt, period;

  assign lock     = wd_active | wd_expired;
  assign count_en = run & rel[0] & rel[1];

  kwdt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .lock_i(lock), .flag_i(timeout_o), .cnt_i(cnt),
    .rdata_o, .run_o(run), .rel_o(rel), .mode_o(mode_q),
    .period_o(period), .cnt_ld_o(cnt_ld), .wdc_wr_o(wdc_wr)
  );

  kwdt_counter #(.HALF_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .rel_i(rel), .count_en_i(count_en),
    .clr_i(svc_clr), .ld_i(cnt_ld), .ld_val_i(wdata_i), .cnt_o(cnt)
  );

  kwdt_keyfsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .wr_i(wdc_wr),
    .key_i(wdata_i[DATA_W-1 -: KEY_W]), .en_i(wdata_i[EN_BIT]),
    .flag_clr_i(wdata_i[FLAG_BIT]), .mode_i(mode_q),
    .cnt_i(cnt), .period_i(period),
    .active_o(wd_active), .expired_o(wd_expired), .svc_clr_o(svc_clr),
    .rst_req_o, .flag_o(timeout_o)
  );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req_o,
  input logic             timeout_o,
  input logic             wdc_wr,
  input logic [31:0]      wdata_i,
  input logic             mode_q,
  input logic             wd_active,
  input logic             wd_expired,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period
);
  logic [KEY_W-1:0] key;
  assign key = wdata_i[31 -: KEY_W];

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r11_flag_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> timeout_o);

  a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(wdc_wr && wdata_i[FLAG_BIT])) |=> timeout_o);

  a_r7_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdc_wr && mode_q && !wd_expired && key != KEY_OPEN && key != KEY_SEAL && key != '0)
      |=> rst_req_o);

  a_r4_threshold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_active && cnt == period) |=> rst_req_o);

  a_r9_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_active || wd_expired) |=> ((wd_active || wd_expired) && mode_q));
endmodule

bind keyed_wdt kwdt_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rst_req_o(rst_req_o), .timeout_o(timeout_o),
  .wdc_wr(wdc_wr), .wdata_i(wdata_i), .mode_q(mode_q), .wd_active(wd_active),
  .wd_expired(wd_expired), .cnt(cnt), .period(period)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  localparam logic [7:0] A_ID = 8'h00, A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18,
                         A_PHI = 8'h1C, A_RUN = 8'h20, A_GLB = 8'h24, A_WDC = 8'h28;
  localparam logic [15:0] K_OPEN = 16'hA5C6, K_SEAL = 16'hDA7E;

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic rst_req_o, timeout_o;
  int n_chk = 0, n_fail = 0;

  keyed_wdt dut_i (.*);

  always #5ns clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; req_i = 1'b1; we_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; req_i = 1'b1; we_i = 1'b0;
    #1ns;
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic wdc(input logic [15:0] key, input logic en, input logic clr);
    bw(A_WDC, {key, clr, en, 14'b0});
  endtask

  task automatic arm();
    wdc(K_OPEN, 1'b1, 1'b0);
    wdc(K_SEAL, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 rst_req", {31'b0, rst_req_o}, 32'd0);
    chk("R1 timeout", {31'b0, timeout_o}, 32'd0);
    br(A_ID, d);  chk("R1 id", d, 32'h5744_0001);
    br(A_CLO, d); chk("R1 cnt_lo", d, 32'd0);
    br(A_GLB, d); chk("R1 glb", d, 32'd0);
    br(A_WDC, d); chk("R1 wdc", d, 32'd0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    do_reset();
    bw(A_RUN, 32'h80);
    repeat (5) @(negedge clk_i);
    br(A_CLO, d); chk("R2 held while unreleased", d, 32'd0);
    bw(A_GLB, 32'h3);
    repeat (4) @(negedge clk_i);
    br(A_CLO, d); chk("R2 counting", d, 32'd4);
    bw(A_CLO, 32'h100);
    br(A_CLO, d); chk("R3 write ignored while running", d, 32'd5);
    bw(A_RUN, 32'h0);
    br(A_CLO, d); chk("R2 stop", d, 32'd6);
    bw(A_CLO, 32'hFFFF_FFFE);
    bw(A_CHI, 32'h7);
    br(A_CLO, d); chk("R3 load lo", d, 32'hFFFF_FFFE);
    br(A_CHI, d); chk("R3 load hi", d, 32'h7);
    bw(A_RUN, 32'h80);
    repeat (3) @(negedge clk_i);
    br(A_CHI, d); chk("R2 carry hi", d, 32'h8);
    br(A_CLO, d); chk("R2 carry lo", d, 32'h1);
    bw(A_GLB, 32'h1);
    @(negedge clk_i);
    br(A_CHI, d); chk("R2 hi held in reset", d, 32'h0);
    br(A_CLO, d); chk("R2 lo stops", d, 32'h2);
  endtask

  task automatic t_arm_expire();
    logic [31:0] d;
    int extra;
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd20);
    bw(A_PHI, 32'd0);
    br(A_PLO, d); chk("R4 period readback", d, 32'd20);
    wdc(K_OPEN, 1'b1, 1'b0);
    br(A_WDC, d); chk("R5 not armed after first key", d, 32'd0);
    wdc(K_SEAL, 1'b1, 1'b0);
    br(A_WDC, d); chk("R5 armed enable bit", d, 32'h4000);
    chk("R5 no timeout on arm", {31'b0, rst_req_o}, 32'd0);
    bw(A_RUN, 32'h80);
    repeat (20) @(negedge clk_i);
    chk("R4 no req before match", {31'b0, rst_req_o}, 32'd0);
    @(negedge clk_i);
    chk("R4 req after match", {31'b0, rst_req_o}, 32'd1);
    chk("R11 flag set", {31'b0, timeout_o}, 32'd1);
    @(negedge clk_i);
    chk("R10 one cycle", {31'b0, rst_req_o}, 32'd0);
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      extra += int'(rst_req_o);
    end
    wdc(16'h5555, 1'b1, 1'b0);
    @(negedge clk_i);
    extra += int'(rst_req_o);
    chk("R10 no second request", extra, 0);
  endtask

  task automatic t_service();
    logic [31:0] d;
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd10);
    arm();
    bw(A_RUN, 32'h80);
    repeat (6) @(negedge clk_i);
    arm();
    br(A_CLO, d); chk("R6 service clears counter", d, 32'd0);
    br(A_CHI, d); chk("R6 service clears hi", d, 32'd0);
    repeat (10) @(negedge clk_i);
    chk("R6 expiry postponed", {31'b0, rst_req_o}, 32'd0);
    @(negedge clk_i);
    chk("R6 expiry after service", {31'b0, rst_req_o}, 32'd1);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd1000);
    wdc(16'h5555, 1'b1, 1'b0);
    chk("R7 invalid key req", {31'b0, rst_req_o}, 32'd1);
    @(negedge clk_i);
    chk("R10 invalid key pulse ends", {31'b0, rst_req_o}, 32'd0);
    wdc(16'h0, 1'b0, 1'b0);
    br(A_WDC, d); chk("R11 write 0 keeps flag", d[15], 1'b1);
    wdc(16'h0, 1'b0, 1'b1);
    chk("R11 w1c clears flag", {31'b0, timeout_o}, 32'd0);
  endtask

  task automatic t_seal_alone();
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd1000);
    wdc(K_SEAL, 1'b1, 1'b0);
    chk("R7 second key alone", {31'b0, rst_req_o}, 32'd1);
  endtask

  task automatic t_key_zero();
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd1000);
    wdc(16'h0, 1'b1, 1'b0);
    chk("R7 zero key ignored", {30'b0, rst_req_o, timeout_o}, 32'd0);
  endtask

  task automatic t_mode_off();
    logic [31:0] d;
    do_reset();
    bw(A_GLB, 32'h3);
    bw(A_PLO, 32'd1000);
    wdc(16'h5555, 1'b1, 1'b0);
    chk("R8 no timeout without mode", {30'b0, rst_req_o, timeout_o}, 32'd0);
    arm();
    br(A_WDC, d); chk("R8 not armed without mode", d, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd1000);
    arm();
    bw(A_GLB, 32'h0);
    br(A_GLB, d); chk("R9 mode locked", d, 32'h8);
    wdc(16'h0, 1'b0, 1'b0);
    br(A_WDC, d); chk("R9 enable locked", d, 32'h4000);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    do_reset();
    bw(A_GLB, 32'hB);
    bw(A_PLO, 32'd5);
    bw(A_PHI, 32'd1);
    bw(A_CHI, 32'd1);
    arm();
    br(A_CHI, d); chk("R5 arm keeps counter", d, 32'd1);
    bw(A_RUN, 32'h80);
    repeat (5) @(negedge clk_i);
    chk("R4 wide no early req", {31'b0, rst_req_o}, 32'd0);
    @(negedge clk_i);
    chk("R4 wide threshold req", {31'b0, rst_req_o}, 32'd1);
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL WDOG: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_counter();
    t_arm_expire();
    t_service();
    t_bad_key();
    t_seal_alone();
    t_key_zero();
    t_mode_off();
    t_lock();
    t_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule